// File: doc/BRIEF.md
# System Timer with Compare Channel

A memory-mapped system timer for a processor subsystem. A wide free-running counter advances by one on every cycle in which the tick-enable input is high. Software reads it through a 32-bit register bus as two separate words, a low half and a high half. Neither read captures the other half. Software detects a carry between the two reads by reading the high word a second time.

A single compare channel holds a 32-bit target that is checked against the low half of the counter only. Software arms the channel by loading the target and setting an enable bit in the control/status word. The channel is detected on the rising edge of equality. When the low half becomes equal to the target while the channel is enabled, a sticky match flag sets. The interrupt output is high while both the flag and the enable bit are set. Software acknowledges by writing a 1 to the flag bit. The counter is never reloaded, so the next event is armed by writing a new target.

Top module: `sys_timer_cmp`

## Requirements
- R1: After reset the counter equals parameter START_COUNT (default 0), and the compare value, match flag, enable bit, timer_irq and bus_rdata are all 0.
- R2: The counter increments by 1 (modulo 2^64) at each clock edge where tick_en is 1 and holds otherwise. The low half carries into the high half. A match never reloads it, and bus writes to word indexes 1 and 2 leave it unchanged.
- R3: The word index selects the register: 0 is control/status (bit 0 match flag, bit 4 enable, other bits read 0), 1 is the counter low half, 2 is the counter high half, and 3 is the compare value. Other indexes read as 0 and ignore writes.
- R4: A read with bus_rd high at a clock edge presents the addressed value as it stood before that edge on bus_rdata from that edge on. bus_rdata holds until the next read.
- R5: The compare register is a 32-bit read/write value. It changes only on a write to index 3.
- R6: While the enable bit is 1, the cycle in which the low counter half first becomes equal to the compare value causes the match flag to be 1 from the next clock edge.
- R7: While the enable bit is 0, no new match sets the flag. Clearing the enable bit leaves an already set flag unchanged.
- R8: Writing index 0 with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. The same write loads bit 4 into the enable bit.
- R9: timer_irq is 1 exactly when the match flag and the enable bit are both 1.
- R10: If a flag-clearing write and a new match occur at the same edge, the flag stays 1.
- R11: An equality that persists (the counter is stalled at the compare value) sets the flag only once. After it is cleared, the flag stays 0 until the equality ends and occurs again.
- R12: The high and low words are independent reads. A high word read after a low word read reflects any carry that occurred between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advances at each edge where this is high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (4) | Word index of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| timer_irq | output | 1 | Compare interrupt, flag AND enable |

## Verification
Properties checked on every cycle:
- The counter steps by one or holds, following tick_en.
- The compare value is stable except on its own write.
- A match edge always leaves the flag set.
- The flag survives every cycle without a clearing write.
- It never sets while the channel is disabled.
- The interrupt is low whenever the enable bit is low.

The bench scenarios cover what needs a history to show:
- A carry seen between a low read and a later high read.
- The compare firing across the 32-bit wrap.
- A clear that collides with a fresh match.
- A stalled equality that must not fire a second time after it has been acknowledged.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
   // word indexes of the register window
   localparam int IDX_CTRL = 0;
   localparam int IDX_LO   = 1;
   localparam int IDX_HI   = 2;
   localparam int IDX_CMP  = 3;
   // bit positions inside the control/status word
   localparam int FLAG_BIT = 0;
   localparam int EN_BIT   = 4;
endpackage

// File: rtl/stmr_count.sv
module stmr_count #(
   parameter int CNT_W  = 64,
   parameter int HALF_W = 32,
   parameter bit SPLIT  = 1'b1,
   parameter logic [CNT_W-1:0] START = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] count
);
   localparam int HI_W = CNT_W - HALF_W;

   generate
      if (SPLIT) begin : g_split
         // two halves with an explicit carry: shorter adder per stage
         logic [HALF_W-1:0] lo_q;
         logic [HI_W-1:0]   hi_q;
         logic              lo_full;
         assign lo_full = &lo_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lo_q <= START[HALF_W-1:0];
               hi_q <= START[CNT_W-1:HALF_W];
            end else if (tick_en) begin
               lo_q <= lo_q + 1'b1;
               if (lo_full) hi_q <= hi_q + 1'b1;
            end
         end
         assign count = {hi_q, lo_q};
      end else begin : g_flat
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       cnt_q <= START;
            else if (tick_en) cnt_q <= cnt_q + 1'b1;
         end
         assign count = cnt_q;
      end
   endgenerate

   // R2: one step per enabled tick, frozen otherwise
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> count == $past(count) + {{(CNT_W-1){1'b0}}, 1'b1});
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count));
endmodule

// File: rtl/stmr_match.sv
module stmr_match #(
   parameter int CMP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] cnt_lo,
   input  logic [CMP_W-1:0] cmp_val,
   input  logic             cmp_en,
   input  logic             clr_req,
   output logic             flag,
   output logic             irq
);
   logic eq_now;
   logic eq_q;
   logic hit;

   assign eq_now = (cnt_lo == cmp_val);
   // rising edge of equality: a stalled counter yields a single event
   assign hit    = cmp_en && eq_now && !eq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eq_q <= 1'b0;
         flag <= 1'b0;
      end else begin
         eq_q <= eq_now;
         // a fresh match outranks a clearing write
         if (hit)          flag <= 1'b1;
         else if (clr_req) flag <= 1'b0;
      end
   end

   assign irq = flag && cmp_en;

   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
   p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr_req |=> flag);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && !hit |=> !flag);
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en && !flag |=> !flag);
   p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && hit |=> flag);
endmodule

// File: rtl/stmr_regfile.sv
module stmr_regfile
   import stmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int AW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              flag,
   output logic [DATA_W-1:0] cmp_val,
   output logic              cmp_en,
   output logic              clr_req,
   output logic [DATA_W-1:0] rdata
);
   logic sel_ctrl, sel_lo, sel_hi, sel_cmp;
   logic [DATA_W-1:0] rd_mux;

   assign sel_ctrl = (addr == AW'(IDX_CTRL));
   assign sel_lo   = (addr == AW'(IDX_LO));
   assign sel_hi   = (addr == AW'(IDX_HI));
   assign sel_cmp  = (addr == AW'(IDX_CMP));

   assign clr_req = wr_en && sel_ctrl && wdata[FLAG_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_val <= '0;
         cmp_en  <= 1'b0;
      end else if (wr_en) begin
         if (sel_cmp)  cmp_val <= wdata;
         if (sel_ctrl) cmp_en  <= wdata[EN_BIT];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel_ctrl) begin
         rd_mux[FLAG_BIT] = flag;
         rd_mux[EN_BIT]   = cmp_en;
      end else if (sel_lo) begin
         rd_mux = count[DATA_W-1:0];
      end else if (sel_hi) begin
         rd_mux = count[CNT_W-1:DATA_W];
      end else if (sel_cmp) begin
         rd_mux = cmp_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel_cmp) |=> $stable(cmp_val));
   p_cmp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && sel_cmp |=> cmp_val == $past(wdata));
   p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: rtl/sys_timer_cmp.sv
module sys_timer_cmp #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int AW     = 4,
   parameter bit SPLIT_COUNT = 1'b1,
   parameter logic [CNT_W-1:0] START_COUNT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              timer_irq
);
   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("counter must be exactly two bus words wide");
      end
      if (DATA_W <= stmr_pkg::EN_BIT) begin : g_bad_data
         $error("bus word too narrow for the enable bit");
      end
      if (AW < 2) begin : g_bad_aw
         $error("address must reach four words");
      end
   endgenerate

   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] cmp_val;
   logic              cmp_en;
   logic              clr_req;
   logic              flag;

   stmr_count #(
      .CNT_W (CNT_W),
      .HALF_W(DATA_W),
      .SPLIT (SPLIT_COUNT),
      .START (START_COUNT)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_en(tick_en),
      .count  (count)
   );

   stmr_regfile #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W),
      .AW    (AW)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .rd_en  (bus_rd),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .count  (count),
      .flag   (flag),
      .cmp_val(cmp_val),
      .cmp_en (cmp_en),
      .clr_req(clr_req),
      .rdata  (bus_rdata)
   );

   stmr_match #(
      .CMP_W(DATA_W)
   ) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_lo (count[DATA_W-1:0]),
      .cmp_val(cmp_val),
      .cmp_en (cmp_en),
      .clr_req(clr_req),
      .flag   (flag),
      .irq    (timer_irq)
   );

   // R9: interrupt never escapes a disabled channel
   p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |-> !timer_irq);
   // R2: counter writes leave the count untouched when ticks are off
   p_cnt_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !tick_en |=> $stable(count));
endmodule

// File: tb/sys_timer_cmp_bench.sv
module sys_timer_cmp_bench;
   localparam logic [63:0] START = 64'h0000_0002_FFFF_FFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        timer_irq;

   int n_checks = 0;
   int n_fail   = 0;
   logic [63:0] m_cnt;

   always #5 clk = ~clk;

   sys_timer_cmp #(.START_COUNT(START)) u_sys_timer_cmp (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq)
   );

   // independent count model from R1/R2
   always @(posedge clk) begin
      if (!rst_n)       m_cnt <= START;
      else if (tick_en) m_cnt <= m_cnt + 64'd1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   typedef struct packed {
      logic        is_wr;
      logic [3:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 4'd0, 32'h0,         32'h0,         8'd1},  // R1 ctrl
      '{1'b0, 4'd3, 32'h0,         32'h0,         8'd1},  // R1 compare
      '{1'b0, 4'd1, 32'h0,         32'hFFFF_FFF0, 8'd1},  // R1 start low
      '{1'b1, 4'd3, 32'hA5A5_0001, 32'h0,         8'd5},
      '{1'b0, 4'd3, 32'h0,         32'hA5A5_0001, 8'd5},  // R5
      '{1'b1, 4'd0, 32'h0000_0010, 32'h0,         8'd3},
      '{1'b0, 4'd0, 32'h0,         32'h0000_0010, 8'd3},  // R3 enable bit
      '{1'b1, 4'd1, 32'h0000_1234, 32'h0,         8'd2},
      '{1'b0, 4'd1, 32'h0,         32'hFFFF_FFF0, 8'd2},  // R2 low write ignored
      '{1'b1, 4'd2, 32'h0000_0055, 32'h0,         8'd2},
      '{1'b0, 4'd2, 32'h0,         32'h0000_0002, 8'd2},  // R2 high write ignored
      '{1'b1, 4'd7, 32'hFFFF_FFFF, 32'h0,         8'd3},
      '{1'b0, 4'd7, 32'h0,         32'h0,         8'd3},  // R3 unmapped
      '{1'b1, 4'd0, 32'hFFFF_FFEF, 32'h0,         8'd8},
      '{1'b0, 4'd0, 32'h0,         32'h0,         8'd8}   // R8 enable cleared
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      logic [31:0] lo_seen;
      string tag;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 outputs at reset
      chk("R1 irq", {31'd0, timer_irq}, 32'h0);
      chk("R1 rdata", bus_rdata, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_wr) wr(VEC[i].addr, VEC[i].data);
         else begin
            rd(VEC[i].addr, v);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            chk(tag, v, VEC[i].exp);
         end
      end

      // R6 / R12: match across the low-half wrap, carry seen between reads
      wr(4'd3, 32'h0000_0003);
      wr(4'd0, 32'h0000_0010);
      rd(4'd1, lo_seen);
      chk("R12 low before wrap", lo_seen, 32'hFFFF_FFF0);
      ticks(20);
      rd(4'd0, v);
      chk("R6 flag after wrap match", v, 32'h0000_0011);
      chk("R9 irq with flag and enable", {31'd0, timer_irq}, 32'h1);
      rd(4'd2, v);
      chk("R12 high shows carry", v, m_cnt[63:32]);
      rd(4'd1, v);
      chk("R2 low continues past match", v, m_cnt[31:0]);

      // R8: writing zero to the flag bit keeps it
      wr(4'd0, 32'h0000_0010);
      rd(4'd0, v);
      chk("R8 zero write keeps flag", v, 32'h0000_0011);

      // R7 / R9: disable keeps flag, masks interrupt
      wr(4'd0, 32'h0000_0000);
      rd(4'd0, v);
      chk("R7 disable keeps flag", v, 32'h0000_0001);
      chk("R9 irq masked", {31'd0, timer_irq}, 32'h0);
      wr(4'd0, 32'h0000_0010);
      chk("R9 irq returns", {31'd0, timer_irq}, 32'h1);

      // R8: write one clears
      wr(4'd0, 32'h0000_0011);
      rd(4'd0, v);
      chk("R8 w1c", v, 32'h0000_0010);
      chk("R9 irq after clear", {31'd0, timer_irq}, 32'h0);

      // R7: disabled channel ignores a passing equality
      wr(4'd0, 32'h0000_0000);
      wr(4'd3, m_cnt[31:0] + 32'd3);
      ticks(6);
      rd(4'd0, v);
      chk("R7 no match while disabled", v, 32'h0);

      // R10: clear collides with a fresh match
      wr(4'd0, 32'h0000_0010);
      wr(4'd3, m_cnt[31:0] + 32'd2);
      ticks(4);
      rd(4'd0, v);
      chk("R6 second match", v, 32'h0000_0011);
      wr(4'd3, m_cnt[31:0]);        // equality begins at this edge
      wr(4'd0, 32'h0000_0011);      // match and clear at the same edge
      rd(4'd0, v);
      chk("R10 match beats clear", v, 32'h0000_0011);

      // R11: stalled equality fires once
      wr(4'd0, 32'h0000_0011);
      repeat (3) @(negedge clk);
      rd(4'd0, v);
      chk("R11 no refire on stall", v, 32'h0000_0010);
      rd(4'd3, v);
      chk("R5 compare kept", v, m_cnt[31:0]);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule